// File: doc/BRIEF.md
# Bit-Stuffing Frame Codec

This block frames and unframes a bit-oriented serial link. On the send side it takes the bytes of a frame over a valid/ready handshake and puts them on a one-bit line. The frame goes out as an opening flag, then the body with a 0 inserted after every five consecutive 1s, then a closing flag. While no frame data is waiting, the line carries back-to-back flags. The flag is the 8-bit pattern 01111110. Because of the inserted zeros, that pattern never appears inside a body.

On the receive side it watches a one-bit line. It recognises flags, removes the inserted zeros and packs the remaining body bits into bytes. It marks the first byte of each frame and signals the end of each frame. It also reports two faults: a frame whose body is not a whole number of bytes, and an abort sequence of seven or more 1s. Both directions advance by one bit on each cycle in which the shared bit enable is high. The stuffing logic makes no assumption about where byte boundaries fall.

Top module: `bitframe_codec`

## Requirements
- R1: With no byte offered, the transmit line carries continuous flags 01111110 with the leftmost 0 sent first, so the line reads 0,1,1,1,1,1,1,0 repeatedly from the first enabled bit after reset.
- R2: Body bits go out least significant bit first. A 0 is inserted after every run of five body 1s, including runs that cross a byte boundary and a run that ends on the final bit before the closing flag. Flag bits are never stuffed, and the transmit line never shows more than six 1s in a row.
- R3: `tx_ready` is high only in a cycle with `bit_en` high. It rises on the last bit of a flag, or on the last bit of a byte that is not marked last. A byte transfers when `tx_valid` and `tx_ready` are both high. No byte is taken while an inserted 0 is sent, so consecutive bytes are taken exactly as many enabled bits apart as the line bits of the first byte, inserted zeros included.
- R4: The closing flag follows a byte sent with `tx_last` high straight after its final body bit, or after its inserted 0 if one is due. That closing flag may also serve as the opening flag of the next frame.
- R5: When a byte not marked last finishes and no next byte is valid, the transmitter closes the frame with a flag.
- R6: Neither line state nor receive outputs change in a cycle without `bit_en`. `tx_line` holds its value, and no receive pulse follows a cycle with `bit_en` low.
- R7: The receiver drops each 0 that follows five 1s inside a frame and assembles bytes least significant bit first. Each byte is presented with a one-cycle `rx_valid` pulse. `rx_sof` is high with the first byte of a frame only.
- R8: A flag that arrives after at least one body bit pulses `rx_eof` for one cycle. `rx_err` is high with it exactly when the body bit count is not a multiple of eight, and any trailing partial byte is discarded. Flags with no body between them produce no output.
- R9: Seven 1s in a row inside a frame that holds at least one body bit pulse `rx_abort`. The frame then gets no `rx_eof`, and nothing is received until the next flag. A line held at 1 outside a frame produces no output.
- R10: During and straight after reset, `tx_line` is 1 and `tx_ready`, `rx_valid`, `rx_sof`, `rx_eof`, `rx_err` and `rx_abort` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One serial bit is sent and one received in each cycle where this is high |
| tx_data | input | DATA_W | Byte offered for transmission |
| tx_last | input | 1 | Offered byte is the final byte of its frame |
| tx_valid | input | 1 | Offered byte is valid |
| tx_ready | output | 1 | Transmitter takes the offered byte this cycle |
| tx_line | output | 1 | Serial transmit line |
| rx_line | input | 1 | Serial receive line |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| rx_sof | output | 1 | With `rx_valid`: byte is the first of its frame |
| rx_eof | output | 1 | One-cycle pulse: frame closed by a flag |
| rx_err | output | 1 | With `rx_eof`: body length was not a whole number of bytes |
| rx_abort | output | 1 | One-cycle pulse: frame dropped on an abort sequence |

## Verification
A correct transmitter never sends a closing flag off a byte boundary, and it never sends seven 1s. The alignment fault and the abort path therefore cannot be reached through a loopback. For those cases the bench detaches the receive line from the transmitter and drives hand-built bit strings: a 12-bit body between flags, and two bytes followed by a run of seven 1s. A closing flag straight after an inserted 0 is also rare. It occurs only for byte values whose top bits complete a run of five 1s. Sweeping all 256 single-byte frames reaches every such case, and for each one the bench compares the whole line sequence against an arithmetically stuffed copy.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int          FLAG_W       = 8;
    localparam logic [7:0]  FLAG_PATTERN = 8'h7E;
    localparam logic [2:0]  RUN_STUFF    = 3'd5;
    localparam logic [2:0]  RUN_FLAG     = 3'd6;
    localparam logic [2:0]  RUN_ABORT    = 3'd7;

    typedef enum logic [1:0] {
        TX_FLAG = 2'd0,
        TX_DATA = 2'd1,
        TX_TAIL = 2'd2
    } tx_state_e;
endpackage

// File: rtl/bf_tx.sv
module bf_tx
    import bf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              line_o
);
    localparam int CW  = $clog2(DATA_W);
    localparam int FCW = $clog2(FLAG_W);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     bcnt;
        logic [FCW-1:0]    fcnt;
        logic [2:0]        ones;
        logic              last;
        logic              line;
    } tx_regs_t;

    tx_regs_t   r_d, r_q;
    logic       flag_end, stuff_now, byte_end, take;
    logic [2:0] nones;

    always_comb begin
        r_d       = r_q;
        nones     = r_q.ones;
        flag_end  = (r_q.st == TX_FLAG) && (r_q.fcnt == FCW'(FLAG_W - 1));
        stuff_now = (r_q.st == TX_DATA) && (r_q.ones == RUN_STUFF);
        byte_end  = (r_q.st == TX_DATA) && !stuff_now && (r_q.bcnt == CW'(DATA_W - 1));
        in_ready  = bit_en && (flag_end || (byte_end && !r_q.last));
        take      = in_ready && in_valid;
        if (bit_en) begin
            unique case (r_q.st)
                TX_FLAG: begin
                    r_d.line = FLAG_PATTERN[r_q.fcnt];
                    r_d.fcnt = r_q.fcnt + 1'b1;
                    r_d.ones = '0;
                end
                TX_DATA: begin
                    if (stuff_now) begin
                        r_d.line = 1'b0;
                        r_d.ones = '0;
                    end else begin
                        r_d.line = r_q.sh[0];
                        nones    = r_q.sh[0] ? (r_q.ones + 3'd1) : 3'd0;
                        r_d.ones = nones;
                        r_d.sh   = r_q.sh >> 1;
                        r_d.bcnt = r_q.bcnt + 1'b1;
                        if (byte_end && !take) begin
                            r_d.fcnt = '0;
                            r_d.st   = (nones == RUN_STUFF) ? TX_TAIL : TX_FLAG;
                        end
                    end
                end
                TX_TAIL: begin
                    r_d.line = 1'b0;
                    r_d.ones = '0;
                    r_d.fcnt = '0;
                    r_d.st   = TX_FLAG;
                end
                default: begin
                    r_d.fcnt = '0;
                    r_d.st   = TX_FLAG;
                end
            endcase
            if (take) begin
                r_d.st   = TX_DATA;
                r_d.sh   = in_data;
                r_d.bcnt = '0;
                r_d.last = in_last;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= TX_FLAG;
            r_q.line <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.line;
endmodule

// File: rtl/bf_rx_hold.sv
module bf_rx_hold #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic flush,
    input  logic din,
    output logic rel_valid,
    output logic rel_bit
);
    localparam int NW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] pend;
        logic [NW-1:0]    cnt;
    } hold_regs_t;

    hold_regs_t r_d, r_q;
    logic       full;

    always_comb begin
        r_d       = r_q;
        full      = (r_q.cnt == NW'(DEPTH));
        rel_valid = push && full;
        rel_bit   = r_q.pend[0];
        if (flush) begin
            r_d.cnt = '0;
        end else if (push) begin
            r_d.pend = {din, r_q.pend[DEPTH-1:1]};
            if (!full) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/bf_rx.sv
module bf_rx
    import bf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              line_i,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              out_abort
);
    localparam int CW     = $clog2(DATA_W);
    localparam int HOLD_D = int'(RUN_STUFF) + 1;

    typedef struct packed {
        logic [2:0]        ones;
        logic              in_frame;
        logic              got;
        logic              first;
        logic [DATA_W-1:0] asm_sh;
        logic [CW-1:0]     bcnt;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              sof;
        logic              eof;
        logic              err;
        logic              abort;
    } rx_regs_t;

    rx_regs_t          r_d, r_q;
    logic              push, flush, rel_valid, rel_bit;
    logic [DATA_W-1:0] asm_n;

    bf_rx_hold #(.DEPTH(HOLD_D)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .flush     (flush),
        .din       (line_i),
        .rel_valid (rel_valid),
        .rel_bit   (rel_bit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.sof   = 1'b0;
        r_d.eof   = 1'b0;
        r_d.err   = 1'b0;
        r_d.abort = 1'b0;
        push      = 1'b0;
        flush     = 1'b0;
        asm_n     = {rel_bit, r_q.asm_sh[DATA_W-1:1]};
        if (bit_en) begin
            if (line_i) begin
                if (r_q.ones >= RUN_FLAG) begin
                    r_d.abort    = r_q.in_frame && r_q.got;
                    r_d.in_frame = 1'b0;
                    r_d.ones     = RUN_ABORT;
                    flush        = 1'b1;
                end else if (r_q.ones == RUN_STUFF) begin
                    r_d.ones = RUN_FLAG;
                    flush    = 1'b1;
                end else begin
                    r_d.ones = r_q.ones + 3'd1;
                    push     = r_q.in_frame;
                end
            end else begin
                r_d.ones = '0;
                if (r_q.ones == RUN_FLAG) begin
                    if (r_q.in_frame && r_q.got) begin
                        r_d.eof = 1'b1;
                        r_d.err = (r_q.bcnt != '0);
                    end
                    r_d.in_frame = 1'b1;
                    r_d.got      = 1'b0;
                    r_d.first    = 1'b1;
                    r_d.bcnt     = '0;
                    flush        = 1'b1;
                end else if (r_q.ones != RUN_STUFF) begin
                    push = r_q.in_frame;
                end
            end
        end
        if (rel_valid) begin
            r_d.asm_sh = asm_n;
            r_d.got    = 1'b1;
            if (r_q.bcnt == CW'(DATA_W - 1)) begin
                r_d.data  = asm_n;
                r_d.valid = 1'b1;
                r_d.sof   = r_q.first;
                r_d.first = 1'b0;
                r_d.bcnt  = '0;
            end else begin
                r_d.bcnt = r_q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data  = r_q.data;
    assign out_valid = r_q.valid;
    assign out_sof   = r_q.sof;
    assign out_eof   = r_q.eof;
    assign out_err   = r_q.err;
    assign out_abort = r_q.abort;
endmodule

// File: rtl/bitframe_codec.sv
module bitframe_codec #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_line,
    input  logic              rx_line,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_sof,
    output logic              rx_eof,
    output logic              rx_err,
    output logic              rx_abort
);
    bf_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .in_data  (tx_data),
        .in_last  (tx_last),
        .in_valid (tx_valid),
        .in_ready (tx_ready),
        .line_o   (tx_line)
    );

    bf_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .line_i    (rx_line),
        .out_data  (rx_data),
        .out_valid (rx_valid),
        .out_sof   (rx_sof),
        .out_eof   (rx_eof),
        .out_err   (rx_err),
        .out_abort (rx_abort)
    );
endmodule

// File: rtl/bitframe_codec_chk.sv
module bitframe_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_ready,
    input logic tx_line,
    input logic rx_valid,
    input logic rx_sof,
    input logic rx_eof,
    input logic rx_err,
    input logic rx_abort
);
    logic       en_d, en_q;
    logic [2:0] run_d, run_q;

    always_comb begin
        en_d  = bit_en;
        run_d = run_q;
        if (en_q) begin
            run_d = tx_line ? ((run_q == 3'd7) ? 3'd7 : run_q + 3'd1) : 3'd0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            run_q <= '0;
        end else begin
            en_q  <= en_d;
            run_q <= run_d;
        end
    end

    AST_TX_RUN_LIMIT:   assert property (@(posedge clk) disable iff (!rst_n) run_q != 3'd7); // R2
    AST_READY_WITH_EN:  assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> bit_en); // R3
    AST_LINE_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !bit_en |=> $stable(tx_line)); // R6
    AST_RX_QUIET:       assert property (@(posedge clk) disable iff (!rst_n) !bit_en |=> !(rx_valid || rx_eof || rx_abort)); // R6
    AST_VALID_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R7
    AST_SOF_IN_VALID:   assert property (@(posedge clk) disable iff (!rst_n) rx_sof |-> rx_valid); // R7
    AST_ERR_IN_EOF:     assert property (@(posedge clk) disable iff (!rst_n) rx_err |-> rx_eof); // R8
    AST_EOF_NOT_ABORT:  assert property (@(posedge clk) disable iff (!rst_n) !(rx_eof && rx_abort)); // R9
endmodule

bind bitframe_codec bitframe_codec_chk u_chk (.*);

// File: tb/bitframe_codec_bench.sv
module bitframe_codec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_last = 1'b0;
    logic          tx_valid = 1'b0;
    logic          tx_ready, tx_line, rx_line;
    logic [DW-1:0] rx_data;
    logic          rx_valid, rx_sof, rx_eof, rx_err, rx_abort;
    logic          loop_sel = 1'b1;
    logic          drv_bit = 1'b1;

    assign rx_line = loop_sel ? tx_line : drv_bit;

    bitframe_codec #(.DATA_W(DW)) u_bitframe_codec (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .tx_data(tx_data), .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_line(tx_line), .rx_line(rx_line),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_err(rx_err), .rx_abort(rx_abort)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, fails = 0;
    logic [7:0] txq [0:15];
    logic       txl [0:15];
    int txn = 0, txi = 0;
    logic [7:0] rxb [0:15];
    logic       rxs [0:15];
    int rxn = 0, eofn = 0, errn = 0, abortn = 0;
    int run1 = 0, maxrun = 0;
    logic cap [0:63];
    logic expb [0:63];
    int capn = 0, expn = 0;
    logic cap_on = 1'b0;
    int tick_no = 0;
    int hs_tick [0:15];
    logic done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rxn = 0; eofn = 0; errn = 0; abortn = 0; capn = 0; txn = 0; txi = 0;
    endtask

    task automatic tick();
        logic hs;
        @(negedge clk);
        bit_en   = 1'b1;
        tx_valid = (txi < txn);
        tx_data  = txq[txi % 16];
        tx_last  = txl[txi % 16];
        #1;
        hs = tx_valid && tx_ready;
        @(negedge clk);
        bit_en   = 1'b0;
        tx_valid = 1'b0;
        tick_no++;
        if (hs) begin
            hs_tick[txi % 16] = tick_no;
            txi++;
        end
        if (cap_on && capn < 64) begin
            cap[capn] = tx_line;
            capn++;
        end
        if (tx_line) begin
            run1++;
            if (run1 > maxrun) maxrun = run1;
        end else begin
            run1 = 0;
        end
        if (rx_valid) begin
            if (rxn < 16) begin
                rxb[rxn] = rx_data;
                rxs[rxn] = rx_sof;
            end
            rxn++;
        end
        if (rx_eof) begin
            eofn++;
            if (rx_err) errn++;
        end
        if (rx_abort) abortn++;
    endtask

    task automatic push_exp(input logic b);
        if (expn < 64) expb[expn] = b;
        expn++;
    endtask

    // arithmetic model of the line after the opening flag: stuffed body then closing flag
    task automatic build_exp(input logic [7:0] v);
        int ones;
        expn = 0;
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            push_exp(v[i]);
            ones = v[i] ? ones + 1 : 0;
            if (ones == 5) begin
                push_exp(1'b0);
                ones = 0;
            end
        end
        for (int i = 0; i < 8; i++) push_exp(8'h7E >> i);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            drv_bit = v[i];
            tick();
        end
    endtask

    task automatic wait_taken(input int n);
        int guard;
        guard = 0;
        while (txi < n && guard < 200) begin
            tick();
            guard++;
        end
    endtask

    initial begin
        int mism;
        logic [7:0] bv;
        int len;
        for (int i = 0; i < 16; i++) begin
            txq[i] = '0;
            txl[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(tx_line === 1'b1 && tx_ready === 1'b0 && rx_valid === 1'b0 && rx_eof === 1'b0
              && rx_abort === 1'b0 && rx_sof === 1'b0 && rx_err === 1'b0, "R10", tx_line, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line === 1'b1 && rx_valid === 1'b0, "R10", tx_line, 1);

        // R1: idle flags from the first enabled bit
        clear_logs();
        cap_on = 1'b1;
        repeat (16) tick();
        cap_on = 1'b0;
        mism = 0;
        for (int i = 0; i < 16; i++) if (cap[i] !== ((8'h7E >> (i % 8)) & 1)) mism++;
        check(mism == 0, "R1", mism, 0);

        // R6: no enable, line holds
        bv = {7'b0, tx_line};
        repeat (7) @(negedge clk);
        check(tx_line === bv[0] && tx_ready === 1'b0, "R6", tx_line, bv[0]);

        // R2/R7/R8: sweep of all single-byte frames in loopback
        for (int v = 0; v < 256; v++) begin
            clear_logs();
            txq[0] = 8'(v); txl[0] = 1'b1; txn = 1;
            wait_taken(1);
            build_exp(8'(v));
            cap_on = 1'b1;
            repeat (expn) tick();
            cap_on = 1'b0;
            mism = 0;
            for (int k = 0; k < expn; k++) if (cap[k] !== expb[k]) mism++;
            check(mism == 0, "R2", mism, 0);
            repeat (2) tick();
            check(rxn == 1 && rxb[0] == 8'(v) && rxs[0] == 1'b1, "R7", int'(rxb[0]), v);
            check(eofn == 1 && errn == 0, "R8", eofn, 1);
        end

        // R3: bytes taken exactly one line byte apart, inserted zeros included
        clear_logs();
        txq[0] = 8'hFF; txl[0] = 1'b0; txq[1] = 8'hFF; txl[1] = 1'b0; txq[2] = 8'h00; txl[2] = 1'b1; txn = 3;
        wait_taken(3);
        check(hs_tick[1] - hs_tick[0] == 9, "R3", hs_tick[1] - hs_tick[0], 9);
        check(hs_tick[2] - hs_tick[1] == 10, "R3", hs_tick[2] - hs_tick[1], 10);
        repeat (30) tick();
        check(rxn == 3 && rxb[0] == 8'hFF && rxb[1] == 8'hFF && rxb[2] == 8'h00 && eofn == 1, "R3", rxn, 3);

        // R4: multi-byte frames, computed contents
        for (int f = 0; f < 8; f++) begin
            clear_logs();
            len = 2 + (f % 3);
            for (int k = 0; k < len; k++) begin
                txq[k] = 8'((f * 53 + k * 97 + 31) & 255);
                txl[k] = (k == len - 1);
            end
            txn = len;
            wait_taken(len);
            repeat (30) tick();
            mism = 0;
            for (int k = 0; k < len; k++) begin
                if (rxb[k] !== txq[k]) mism++;
                if (rxs[k] !== (k == 0)) mism++;
            end
            check(rxn == len && mism == 0, "R4", mism, 0);
            check(eofn == 1 && errn == 0 && abortn == 0, "R4", eofn, 1);
        end

        // R4: back-to-back frames sharing a flag
        clear_logs();
        txq[0] = 8'h7E; txl[0] = 1'b1; txq[1] = 8'h3F; txl[1] = 1'b0; txq[2] = 8'hFC; txl[2] = 1'b1; txn = 3;
        wait_taken(3);
        repeat (30) tick();
        check(eofn == 2 && errn == 0, "R4", eofn, 2);
        check(rxn == 3 && rxs[0] && rxs[1] && !rxs[2] && rxb[0] == 8'h7E && rxb[2] == 8'hFC, "R4", rxn, 3);

        // R5: underrun closes the frame
        clear_logs();
        txq[0] = 8'h5A; txl[0] = 1'b0; txn = 1;
        wait_taken(1);
        repeat (30) tick();
        check(rxn == 1 && rxb[0] == 8'h5A && eofn == 1 && errn == 0, "R5", eofn, 1);

        // R2: transmit line never showed seven ones
        check(maxrun <= 6, "R2", maxrun, 6);

        // Receive-only stimulus from here
        loop_sel = 1'b0;
        // R9: idle line of ones outside a frame
        clear_logs();
        send_bits(64'hFFFFFF, 24);
        check(rxn == 0 && eofn == 0 && abortn == 0, "R9", rxn + eofn + abortn, 0);
        // R8: empty frames give nothing
        clear_logs();
        send_bits(64'h7E7E7E, 24);
        check(rxn == 0 && eofn == 0 && abortn == 0, "R8", rxn + eofn + abortn, 0);
        // R8: 12-bit body gives one byte then an eof with the alignment flag
        clear_logs();
        send_bits(64'h7E, 8);
        send_bits(64'h5A5, 12);
        send_bits(64'h7E7E, 16);
        check(rxn == 1 && rxb[0] == 8'hA5, "R8", int'(rxb[0]), 8'hA5);
        check(eofn == 1 && errn == 1, "R8", errn, 1);
        // R9: abort after two bytes
        clear_logs();
        send_bits(64'h7E, 8);
        send_bits(64'h423C, 16);
        send_bits(64'h7F, 7);
        send_bits(64'h7E7E, 16);
        check(rxn == 1 && rxb[0] == 8'h3C && abortn == 1, "R9", abortn, 1);
        check(eofn == 0, "R9", eofn, 0);
        // R7: explicit stuffed zero removal: 0xFF body as 11111 0 111
        clear_logs();
        send_bits(64'h7E, 8);
        send_bits(64'h1DF, 9);
        send_bits(64'h7E7E, 16);
        check(rxn == 1 && rxb[0] == 8'hFF && eofn == 1 && errn == 0, "R7", int'(rxb[0]), 8'hFF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule